// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block holds and advances the instruction fetch address of a small 8-bit controller core. The address is 13 bits wide. Its low byte also acts as a data register that the ALU can read and overwrite. The upper five bits are never written directly. They are loaded from a 5-bit page latch, which software writes ahead of time. Writing the low byte and taking a jump use different bits of that latch.

Decode logic, the ALU, program memory and the interrupt controller sit outside the block. They drive single-cycle strobes and data into it. A call or an interrupt saves its return address on an 8-deep return stack. The stack wraps silently, so a ninth push replaces the oldest entry. A return takes the address back off the stack.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, the fetch address is 0x0000 and the low-byte readback is 0x00.
- R2: The low-byte readback always equals fetch address bits 7:0.
- R3: If no load strobe is active, an asserted advance strobe adds one to the address, modulo 2^13, so 0x1FFF goes to 0x0000. With no strobe active, the address holds.
- R4: A low-byte write sets the address to {latch[4:0], data[7:0]}, so all 13 bits change in one cycle. The latch value used is the one held before that clock edge.
- R5: A jump sets address bits 10:0 from the 11-bit target and bits 12:11 from latch bits 4:3.
- R6: A call loads the address the same way a jump does. It also pushes the old address plus one, modulo 2^13, onto the stack.
- R7: An interrupt pushes the current address unchanged and then loads the vector address 0x004.
- R8: A return pops the stack. The pointer is first decremented and then that slot is read, and the slot becomes the full 13-bit address. The latch plays no part in a return.
- R9: The stack holds 8 entries and is circular. The ninth push overwrites the first, and pops past the bottom wrap the pointer and return whatever that slot holds.
- R10: Pushes and pops leave the page latch unchanged.
- R11: If several strobes arrive together, the highest-priority one acts and the rest are ignored. From highest to lowest the order is: interrupt, return, call, jump, low-byte write, advance. A latch write in the same cycle affects only later loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance the address by one |
| lowwr_i | input | 1 | ALU write to the low-byte register |
| lowwr_data_i | input | 8 | Data for the low-byte write |
| jump_i | input | 1 | Jump to the paged target |
| call_i | input | 1 | Call the paged target and push the return address |
| target_i | input | 11 | Target address field from the opcode |
| irq_i | input | 1 | Vector to the interrupt address |
| ret_i | input | 1 | Any return: pop the stack |
| latch_wr_i | input | 1 | Write the page latch |
| latch_data_i | input | 5 | Data for the page latch |
| fetch_addr_o | output | 13 | Current fetch address |
| low_rd_o | output | 8 | Readback of the low byte |

## Verification
The bench drives directed sequences that give different results for different bit selections. Latch values whose bits 2:0 differ from bits 4:3 separate a low-byte write from a jump. A low-byte write at 0x1FFF followed by an advance, and a call from there, check wrap-around of the increment and of the pushed value. Nine calls followed by nine returns check that the oldest entry is overwritten and that the pointer wraps. Coincident strobes check the priority order. Seeded random mixes of all operations and latch writes are then compared every cycle against a reference model of the address, latch and stack in the bench.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_ADV   = 3'd1,
    OP_LOWWR = 3'd2,
    OP_JUMP  = 3'd3,
    OP_CALL  = 3'd4,
    OP_IRQ   = 3'd5,
    OP_RET   = 3'd6
  } pc_op_e;

  function automatic pc_op_e decode_op(input logic irq, input logic ret, input logic call,
                                       input logic jump, input logic lowwr, input logic adv);
    if (irq)        return OP_IRQ;
    else if (ret)   return OP_RET;
    else if (call)  return OP_CALL;
    else if (jump)  return OP_JUMP;
    else if (lowwr) return OP_LOWWR;
    else if (adv)   return OP_ADV;
    else            return OP_HOLD;
  endfunction
endpackage

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_data_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  ptr_q, ptr_d, ptr_dec;
  logic [ADDR_W-1:0] slot_q [DEPTH];

  assign ptr_dec = ptr_q - PTR_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (push_i)     ptr_d = ptr_q + PTR_W'(1);
    else if (pop_i) ptr_d = ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // Each slot has its own write enable; slots hold data only, no reset.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push_i && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q[g] <= push_data_i;
    end
  end

  assign pop_data_o = slot_q[ptr_dec];

  // R9: a push advances the pointer by one, wrapping at DEPTH
  a_r9_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  // R8: a pop steps the pointer back by one, wrapping below zero
  a_r8_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ptr_q == $past(ptr_q) - PTR_W'(1));
  // R9: the slot written by a push holds the pushed value afterwards
  a_r9_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> slot_q[$past(ptr_q)] == $past(push_data_i));
endmodule

// File: rtl/pc_next_select.sv
module pc_next_select
  import pc_sequencer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned LOW_W   = 8,
  parameter int unsigned TGT_W   = 11,
  parameter int unsigned LATCH_W = 5,
  parameter logic [ADDR_W-1:0] VECTOR = 13'h004
) (
  input  pc_op_e             op_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [LOW_W-1:0]   low_data_i,
  input  logic [TGT_W-1:0]   target_i,
  input  logic [ADDR_W-1:0]  pop_data_i,
  output logic [ADDR_W-1:0]  pc_next_o,
  output logic               push_o,
  output logic [ADDR_W-1:0]  push_data_o,
  output logic               pop_o
);
  localparam int unsigned PAGE_W = ADDR_W - TGT_W;

  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] paged_target;
  logic [ADDR_W-1:0] low_load;

  assign pc_inc       = pc_i + ADDR_W'(1);
  assign paged_target = {latch_i[LATCH_W-1 -: PAGE_W], target_i};
  assign low_load     = {latch_i, low_data_i};

  always_comb begin
    pc_next_o   = pc_i;
    push_o      = 1'b0;
    push_data_o = pc_inc;
    pop_o       = 1'b0;
    unique case (op_i)
      OP_ADV:   pc_next_o = pc_inc;
      OP_LOWWR: pc_next_o = low_load;
      OP_JUMP:  pc_next_o = paged_target;
      OP_CALL: begin
        pc_next_o   = paged_target;
        push_o      = 1'b1;
        push_data_o = pc_inc;
      end
      OP_IRQ: begin
        pc_next_o   = VECTOR;
        push_o      = 1'b1;
        push_data_o = pc_i;
      end
      OP_RET: begin
        pc_next_o = pop_data_i;
        pop_o     = 1'b1;
      end
      default:  pc_next_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_sequencer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned LOW_W   = 8,
  parameter int unsigned TGT_W   = 11,
  parameter int unsigned DEPTH   = 8,
  parameter logic [12:0] VECTOR  = 13'h004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv_i,
  input  logic        lowwr_i,
  input  logic [7:0]  lowwr_data_i,
  input  logic        jump_i,
  input  logic        call_i,
  input  logic [10:0] target_i,
  input  logic        irq_i,
  input  logic        ret_i,
  input  logic        latch_wr_i,
  input  logic [4:0]  latch_data_i,
  output logic [12:0] fetch_addr_o,
  output logic [7:0]  low_rd_o
);
  localparam int unsigned LATCH_W = ADDR_W - LOW_W;

  pc_op_e             op;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic [LATCH_W-1:0] latch_q, latch_d;
  logic               push, pop;
  logic [ADDR_W-1:0]  push_data, pop_data;

  assign op = decode_op(irq_i, ret_i, call_i, jump_i, lowwr_i, adv_i);

  pc_next_select #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .TGT_W(TGT_W), .LATCH_W(LATCH_W), .VECTOR(VECTOR)
  ) u_next (
    .op_i        (op),
    .pc_i        (pc_q),
    .latch_i     (latch_q),
    .low_data_i  (lowwr_data_i),
    .target_i    (target_i),
    .pop_data_i  (pop_data),
    .pc_next_o   (pc_d),
    .push_o      (push),
    .push_data_o (push_data),
    .pop_o       (pop)
  );

  pc_return_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .pop_data_o  (pop_data)
  );

  always_comb begin
    latch_d = latch_q;
    if (latch_wr_i) latch_d = latch_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      latch_q <= '0;
    end else begin
      pc_q    <= pc_d;
      latch_q <= latch_d;
    end
  end

  assign fetch_addr_o = pc_q;
  assign low_rd_o     = pc_q[LOW_W-1:0];

  // R3: plain advance is +1 modulo the address width
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !irq_i && !ret_i && !call_i && !jump_i && !lowwr_i)
      |=> fetch_addr_o == $past(fetch_addr_o) + 13'd1);
  // R4: low-byte write loads all latch bits above the written byte
  a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lowwr_i && !irq_i && !ret_i && !call_i && !jump_i)
      |=> fetch_addr_o == {$past(latch_q), $past(lowwr_data_i)});
  // R5: jump takes only the two top latch bits as page
  a_r5_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_i && !irq_i && !ret_i && !call_i)
      |=> fetch_addr_o == {$past(latch_q[4:3]), $past(target_i)});
  // R7: interrupt lands on the vector
  a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> fetch_addr_o == VECTOR);
  // R10: stack traffic leaves the page latch alone
  a_r10_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((push || pop) && !latch_wr_i) |=> $stable(latch_q));
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i, lowwr_i, jump_i, call_i, irq_i, ret_i, latch_wr_i;
  logic [7:0]  lowwr_data_i;
  logic [10:0] target_i;
  logic [4:0]  latch_data_i;
  logic [12:0] fetch_addr_o;
  logic [7:0]  low_rd_o;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [12:0] m_pc;
  logic [4:0]  m_latch;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp;

  always #2 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .lowwr_i(lowwr_i), .lowwr_data_i(lowwr_data_i),
    .jump_i(jump_i), .call_i(call_i), .target_i(target_i), .irq_i(irq_i), .ret_i(ret_i),
    .latch_wr_i(latch_wr_i), .latch_data_i(latch_data_i),
    .fetch_addr_o(fetch_addr_o), .low_rd_o(low_rd_o)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model step following R3..R11, priority irq>ret>call>jump>lowwr>adv
  function automatic void model_step(input logic a, input logic lw, input logic [7:0] ld,
                                     input logic j, input logic c, input logic [10:0] t,
                                     input logic ir, input logic r,
                                     input logic xw, input logic [4:0] xd);
    logic [12:0] nxt;
    nxt = m_pc;
    if (ir) begin
      m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; nxt = 13'h004;
    end else if (r) begin
      m_sp = m_sp - 3'd1; nxt = m_stk[m_sp];
    end else if (c) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; nxt = {m_latch[4:3], t};
    end else if (j) begin
      nxt = {m_latch[4:3], t};
    end else if (lw) begin
      nxt = {m_latch, ld};
    end else if (a) begin
      nxt = m_pc + 13'd1;
    end
    m_pc = nxt;
    if (xw) m_latch = xd;
  endfunction

  task automatic clear_inputs();
    adv_i = 0; lowwr_i = 0; jump_i = 0; call_i = 0; irq_i = 0; ret_i = 0; latch_wr_i = 0;
    lowwr_data_i = '0; target_i = '0; latch_data_i = '0;
  endtask

  // Drive one cycle of strobes, then compare outputs against the model.
  task automatic op(input string req, input logic a, input logic lw, input logic [7:0] ld,
                    input logic j, input logic c, input logic [10:0] t,
                    input logic ir, input logic r, input logic xw, input logic [4:0] xd);
    adv_i = a; lowwr_i = lw; lowwr_data_i = ld; jump_i = j; call_i = c; target_i = t;
    irq_i = ir; ret_i = r; latch_wr_i = xw; latch_data_i = xd;
    model_step(a, lw, ld, j, c, t, ir, r, xw, xd);
    @(negedge clk);
    clear_inputs();
    check(req, fetch_addr_o, m_pc);
    check({req, "/R2"}, {5'd0, low_rd_o}, {5'd0, m_pc[7:0]});
  endtask

  task automatic set_latch(input logic [4:0] v);
    op("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2718));
    clear_inputs();
    m_pc = '0; m_latch = '0; m_sp = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", fetch_addr_o, 13'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", fetch_addr_o, 13'h0000);
    check("R1 low readback", {5'd0, low_rd_o}, 13'h0000);

    // R3: advance and hold
    op("R3 advance", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op("R3 hold", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R4 vs R5: latch 0b10110 separates full-latch and top-two selections
    set_latch(5'b10110);
    op("R4 low write", 0, 1, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
    op("R5 jump", 0, 0, 0, 1, 0, 11'h2C3, 0, 0, 0, 0);

    // R3/R4 wrap: 0x1FFF then advance to 0
    set_latch(5'h1F);
    op("R4 to top", 0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
    op("R3 wrap", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op("R4 to top again", 0, 1, 8'hFF, 0, 0, 0, 0, 0, 0, 0);
    // R6: call from 0x1FFF pushes 0x0000
    op("R6 call wrap", 0, 0, 0, 0, 1, 11'h123, 0, 0, 0, 0);
    // R8: return restores pushed value (0x0000) regardless of latch
    set_latch(5'h0A);
    op("R8 return wrap", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R7: interrupt pushes current pc and vectors
    op("R3 step", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    op("R7 vector", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    op("R8 return from irq", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);

    // R9: nine calls then nine returns (oldest overwritten, pointer wraps)
    for (int k = 0; k < 9; k++)
      op("R9 push", 0, 0, 0, 0, 1, 11'(13 * k + 40), 0, 0, 0, 0);
    for (int k = 0; k < 9; k++)
      op("R9 pop", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);

    // R10: latch unchanged by pushes/pops; a low write reveals it
    set_latch(5'h13);
    op("R10 call", 0, 0, 0, 0, 1, 11'h055, 0, 0, 0, 0);
    op("R10 ret", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    op("R10 latch kept", 0, 1, 8'h81, 0, 0, 0, 0, 0, 0, 0);

    // R11: coincident strobes, priority and same-cycle latch write
    op("R11 irq wins", 1, 1, 8'h11, 1, 1, 11'h7FF, 1, 1, 0, 0);
    op("R11 ret over call", 1, 1, 8'h22, 1, 1, 11'h001, 0, 1, 0, 0);
    op("R11 call over jump", 1, 1, 8'h33, 1, 1, 11'h444, 0, 0, 0, 0);
    op("R11 jump over low", 1, 1, 8'h44, 1, 0, 11'h3A5, 0, 0, 1, 5'h08);
    op("R11 low over adv, new latch", 1, 1, 8'h66, 0, 0, 0, 0, 0, 1, 5'h1C);
    op("R11 latch from next cycle", 0, 1, 8'h77, 0, 0, 0, 0, 0, 0, 0);

    // seeded random mix, compared each cycle to the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] sel;
      sel = 4'($urandom_range(0, 9));
      op("R3-R11 random",
         sel inside {4'd1, 4'd8, 4'd9}, sel == 4'd2, 8'($urandom),
         sel == 4'd3, sel == 4'd4, 11'($urandom),
         sel == 4'd5, sel == 4'd6,
         ($urandom_range(0, 3) == 0), 5'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule